// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block turns an asynchronous serial line back into characters. It uses the same line settings as the transmitter: a word length of 5 to 8 data bits, optional parity with a selectable sense, and the stop position. A shared 16x baud enable (`tick_i`) paces the block. The line input first passes through a synchronizer. A high-to-low transition seen on a tick starts a character. The start bit is confirmed at its middle, and every later bit is sampled at the centre of its bit period.

At the end of each character the block gives a one-cycle `valid_o` pulse together with the received byte and three error flags: parity error, missing stop bit, and break. A break is a character in which every sampled position, stop included, reads 0. It is reported on its own flag and not as a framing error. FIFO buffering, register decoding and interrupts belong to the surrounding logic.

Top module: `uart_frame_rx`

## Requirements
- R1: `len_sel_i` sets the data bit count: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8. Bits arrive LSB first into `data_o[0]` upward, and bits of `data_o` at and above the word length are 0.
- R2: A character starts only when a tick samples the line low after the previous tick sampled it high. The start bit is sampled again 8 ticks later. If it reads 1 there, the attempt is dropped and no `valid_o` is produced.
- R3: With `par_en_i`=1, the bit after the last data bit is taken as parity. With `par_en_i`=0, no parity bit is expected and `par_err_o` stays 0.
- R4: `par_even_i`=1 flags `par_err_o` when data plus parity hold an odd number of ones. `par_even_i`=0 flags it when they hold an even number.
- R5: A first stop bit sampled as 0 raises `stop_err_o` unless the character is a break. Bits after the first stop position are not checked.
- R6: When start, all data bits, the parity bit (if enabled) and the stop bit all sample 0, `break_o`=1, `data_o`=0, and `stop_err_o` and `par_err_o` are 0.
- R7: `valid_o` is a single-cycle pulse per character. The error flags are 0 whenever `valid_o` is 0.
- R8: Word length and parity settings are captured when a start is detected. Changes during a character do not affect that character.
- R9: After a character whose stop bit sampled 0, a new character needs the line to return high before the next falling edge.
- R10: After reset, `valid_o`, `data_o` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 16x baud-rate enable, one cycle wide |
| rxd_i | input | 1 | Serial line, idle high |
| len_sel_i | input | 2 | Word length select (00=5 .. 11=8) |
| par_en_i | input | 1 | Parity bit present and checked |
| par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| data_o | output | 8 | Received character, zero-extended |
| valid_o | output | 1 | Character complete strobe |
| par_err_o | output | 1 | Parity error for this character |
| stop_err_o | output | 1 | First stop bit sampled 0 (not a break) |
| break_o | output | 1 | All positions of the character sampled 0 |

## Verification
On every cycle, the assertions check the following:
- `valid_o` is a single-cycle pulse, and no flag appears without it.
- A break never comes with a parity or stop error, and always comes with a zero byte.
- Unused upper data bits are zero for the captured length.
- The captured settings stay stable for the whole character.
- Reception only proceeds past a start bit that was low at its middle.

Only the bench's scenarios can show that the byte values, the parity sense and the break-versus-framing split are right for real line waveforms. The same goes for rejection of a short glitch, and for the need for the line to go high again after a low stop bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned IDX_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_even;
  } rx_cfg_t;

  function automatic logic [3:0] word_bits(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= 1'b1;
        else         sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_timer.sv
module uart_rx_timer #(
  parameter int unsigned OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic half_o,
  output logic full_o
);
  localparam int unsigned CW   = $clog2(OVS);
  localparam int unsigned HALF = OVS / 2;

  logic [CW-1:0] cnt_q;

  assign half_o = tick_i && (cnt_q == CW'(HALF - 1));
  assign full_o = tick_i && (cnt_q == CW'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (full_o) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  p_half_full_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(half_o && full_o));
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  rx_cfg_t           cfg_i,
  input  logic              half_i,
  input  logic              full_i,
  output logic              tmr_clr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              stop_err_o,
  output logic              break_o
);
  rx_state_e         state_q;
  rx_cfg_t           cfg_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shf_q;
  logic              par_q;
  logic              zero_q;
  logic              prev_q;

  logic [DATA_W-1:0] dout_q;
  logic              valid_q, perr_q, serr_q, brk_q;

  logic              last_bit;
  logic              brk_now;
  logic              par_bad;

  assign last_bit  = ({1'b0, idx_q} == (word_bits(cfg_q.len) - 4'd1));
  assign brk_now   = zero_q && !rx_i;
  // xor of data and parity: 1 means odd count of ones
  assign par_bad   = cfg_q.par_en && ((^shf_q ^ par_q) ^ !cfg_q.par_even);
  assign tmr_clr_o = (state_q == ST_IDLE) || (state_q == ST_START && half_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      idx_q   <= '0;
      shf_q   <= '0;
      par_q   <= 1'b0;
      zero_q  <= 1'b1;
      prev_q  <= 1'b1;
      dout_q  <= '0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      serr_q  <= 1'b0;
      brk_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      serr_q  <= 1'b0;
      brk_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (tick_i) begin
            prev_q <= rx_i;
            if (prev_q && !rx_i) begin
              state_q <= ST_START;
              cfg_q   <= cfg_i;
              shf_q   <= '0;
              par_q   <= 1'b0;
              zero_q  <= 1'b1;
              idx_q   <= '0;
            end
          end
        end
        ST_START: begin
          if (half_i) begin
            if (rx_i) begin
              state_q <= ST_IDLE;
              prev_q  <= 1'b1;
            end else begin
              state_q <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (full_i) begin
            shf_q[idx_q] <= rx_i;
            zero_q       <= zero_q && !rx_i;
            if (last_bit) state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
            else          idx_q   <= idx_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (full_i) begin
            par_q   <= rx_i;
            zero_q  <= zero_q && !rx_i;
            state_q <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (full_i) begin
            valid_q <= 1'b1;
            dout_q  <= shf_q;
            brk_q   <= brk_now;
            serr_q  <= !rx_i && !brk_now;
            perr_q  <= par_bad && !brk_now;
            prev_q  <= rx_i;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_o     = dout_q;
  assign valid_o    = valid_q;
  assign par_err_o  = perr_q;
  assign stop_err_o = serr_q;
  assign break_o    = brk_q;

  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && $past(state_q) == ST_START) |-> !$past(rx_i));
  p_upper_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((data_o >> word_bits(cfg_q.len)) == '0));
  p_no_par_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !cfg_q.par_en) |-> !par_err_o);
  p_break_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |-> (!stop_err_o && !par_err_o && data_o == '0));
  p_valid_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_flags_need_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o || stop_err_o || break_o) |-> valid_o);
  p_cfg_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(cfg_q));
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        rxd_i,
  input  logic [1:0]  len_sel_i,
  input  logic        par_en_i,
  input  logic        par_even_i,
  output logic [7:0]  data_o,
  output logic        valid_o,
  output logic        par_err_o,
  output logic        stop_err_o,
  output logic        break_o
);
  logic    rx_s;
  logic    half, full, tmr_clr;
  rx_cfg_t cfg;

  assign cfg = '{len: len_sel_i, par_en: par_en_i, par_even: par_even_i};

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  uart_rx_timer #(.OVS(OVS)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .clr_i (tmr_clr),
    .half_o(half),
    .full_o(full)
  );

  uart_rx_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rx_i      (rx_s),
    .cfg_i     (cfg),
    .half_i    (half),
    .full_i    (full),
    .tmr_clr_o (tmr_clr),
    .data_o    (data_o),
    .valid_o   (valid_o),
    .par_err_o (par_err_o),
    .stop_err_o(stop_err_o),
    .break_o   (break_o)
  );
endmodule

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i;
  logic       rxd_i = 1'b1;
  logic [1:0] len_sel_i = 2'b11;
  logic       par_en_i = 1'b0;
  logic       par_even_i = 1'b0;
  logic [7:0] data_o;
  logic       valid_o, par_err_o, stop_err_o, break_o;

  always #4 clk_i = ~clk_i;

  logic [1:0] div_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end
  assign tick_i = (div_q == 2'(TICK_DIV - 1));

  uart_frame_rx u_uart_frame_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .rxd_i(rxd_i),
    .len_sel_i(len_sel_i), .par_en_i(par_en_i), .par_even_i(par_even_i),
    .data_o(data_o), .valid_o(valid_o), .par_err_o(par_err_o),
    .stop_err_o(stop_err_o), .break_o(break_o)
  );

  typedef struct {
    logic [7:0] data;
    bit         pe;
    bit         se;
    bit         brk;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_err = 0;
  int   n_valid = 0;
  int   n_glitch = 0;
  bit   done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (valid_o) begin
        n_valid++;
        if (exp_q.size() == 0) begin
          check(0, "R2", "unexpected character", int'(data_o), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(data_o == e.data, e.tag, "data", int'(data_o), int'(e.data));
          check(par_err_o == e.pe, e.tag, "par_err", int'(par_err_o), int'(e.pe));
          check(stop_err_o == e.se, e.tag, "stop_err", int'(stop_err_o), int'(e.se));
          check(break_o == e.brk, e.tag, "break", int'(break_o), int'(e.brk));
        end
      end else if (par_err_o || stop_err_o || break_o) begin
        n_glitch++;
      end
    end
  end

  task automatic drive_bit(input logic b);
    rxd_i = b;
    repeat (BIT_CLKS) @(negedge clk_i);
  endtask

  task automatic idle_bits(input logic lvl, input int n);
    rxd_i = lvl;
    repeat (n * BIT_CLKS) @(negedge clk_i);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [1:0] len,
                            input bit pen, input bit peven, input bit bad_par,
                            input bit stop0, input bit two_stop,
                            input bit scramble, input string tag);
    int         nb;
    logic [7:0] dm;
    logic       pbit;
    exp_t       e;
    nb   = 5 + int'(len);
    dm   = d & 8'((1 << nb) - 1);
    pbit = peven ? ^dm : ~^dm;
    if (bad_par) pbit = ~pbit;
    e.brk  = (dm == 8'h00) && (!pen || !pbit) && stop0;
    e.data = dm;
    e.pe   = pen && bad_par && !e.brk;
    e.se   = stop0 && !e.brk;
    e.tag  = tag;
    exp_q.push_back(e);
    len_sel_i  = len;
    par_en_i   = pen;
    par_even_i = peven;
    drive_bit(1'b0);
    if (scramble) begin
      len_sel_i  = ~len;
      par_en_i   = ~pen;
      par_even_i = ~peven;
    end
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (pen) drive_bit(pbit);
    drive_bit(!stop0);
    if (two_stop && !stop0) drive_bit(1'b1);
  endtask

  initial begin
    repeat (5) @(negedge clk_i);
    // R10 reset state
    check(valid_o == 0, "R10", "valid after reset", int'(valid_o), 0);
    check(data_o == 0, "R10", "data after reset", int'(data_o), 0);
    check({par_err_o, stop_err_o, break_o} == 0, "R10", "flags after reset",
          int'({par_err_o, stop_err_o, break_o}), 0);
    rst_ni = 1'b1;
    idle_bits(1'b1, 2);

    // R1 lengths, no parity
    send_frame(8'hA5, 2'b11, 0, 0, 0, 0, 0, 0, "R1_len8");
    send_frame(8'h5A, 2'b10, 0, 0, 0, 0, 0, 0, "R1_len7");
    send_frame(8'hFF, 2'b01, 0, 0, 0, 0, 0, 0, "R1_len6");
    send_frame(8'hFF, 2'b00, 0, 0, 0, 0, 0, 0, "R1_len5");
    send_frame(8'h13, 2'b00, 0, 0, 0, 0, 1, 0, "R1_len5_twostop");
    idle_bits(1'b1, 1);
    // R3 / R4 parity
    send_frame(8'h81, 2'b11, 1, 1, 0, 0, 0, 0, "R3_even_ok");
    send_frame(8'h07, 2'b11, 1, 0, 0, 0, 0, 0, "R3_odd_ok");
    send_frame(8'h07, 2'b11, 1, 1, 1, 0, 0, 0, "R4_even_bad");
    send_frame(8'h3C, 2'b01, 1, 0, 1, 0, 0, 0, "R4_odd_bad");
    send_frame(8'h1F, 2'b00, 1, 0, 0, 0, 1, 0, "R4_len5_odd_ok");
    // R5 missing stop
    send_frame(8'h42, 2'b11, 0, 0, 0, 1, 0, 0, "R5_stop0");
    idle_bits(1'b1, 1);
    send_frame(8'h99, 2'b11, 1, 1, 1, 1, 0, 0, "R5_stop0_parbad");
    idle_bits(1'b1, 1);
    // R6 break
    send_frame(8'h00, 2'b11, 0, 0, 0, 1, 0, 0, "R6_break");
    idle_bits(1'b1, 1);
    send_frame(8'h00, 2'b10, 1, 1, 0, 1, 0, 0, "R6_break_par");
    idle_bits(1'b1, 1);
    send_frame(8'h00, 2'b11, 1, 0, 0, 1, 0, 0, "R6_zero_oddpar_not_break");
    idle_bits(1'b1, 1);

    // R2 short glitch: low for 4 ticks only
    begin
      int v0;
      v0 = n_valid;
      rxd_i = 1'b0;
      repeat (4 * TICK_DIV) @(negedge clk_i);
      idle_bits(1'b1, 3);
      check(n_valid == v0, "R2", "glitch produced character", n_valid - v0, 0);
    end

    // R8 config changed mid-character
    send_frame(8'hC3, 2'b11, 1, 1, 0, 0, 0, 1, "R8_cfg_held");
    idle_bits(1'b1, 1);

    // R9 line held low after break: no new character until it goes high
    begin
      int v0;
      send_frame(8'h00, 2'b11, 0, 0, 0, 1, 0, 0, "R9_break");
      v0 = n_valid;
      idle_bits(1'b0, 3);
      check(n_valid == v0, "R9", "start while line low", n_valid - v0, 0);
      idle_bits(1'b1, 1);
      send_frame(8'h6E, 2'b11, 0, 0, 0, 0, 0, 0, "R9_after_high");
      idle_bits(1'b1, 1);
    end

    check(exp_q.size() == 0, "R1", "characters missing", exp_q.size(), 0);
    check(n_glitch == 0, "R7", "flag without valid", n_glitch, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule